// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 interrupt inputs and presents a processor with a single request line and a vector that can be read back. Each input has its own trigger mode and a 3-bit priority. Inputs can be high-level, rising-edge, low-level or falling-edge sensitive. The two inverted modes are available only on sources that the `EXT_SRC_MASK` parameter marks as external. A synchronous register port lets software enable and disable sources, drop latched edges, and program each source's mode and vector.

Reading the vector register acknowledges the winning source. The read returns that source's vector, saves the running priority level on an internal stack, and makes the winner's priority the new running level. An end-of-interrupt write restores the saved level. Up to `DEPTH` (8) acknowledgements may nest. When no source qualifies, the read returns a programmable spurious vector and changes nothing.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Writing address 0x00 enables every source whose `wdata` bit is 1. Writing address 0x01 disables every such source. Bits written as 0 leave the enable unchanged. A read of address 0x02 returns the enable bits.
- R2: A source mode register sits at 0x40+n. It holds the priority in bits [2:0] and the trigger in bits [5:4], coded 0 high level, 1 rising edge, 2 low level, 3 falling edge. On a source not marked external, a write carrying trigger 2 or 3 keeps the old trigger and still updates the priority. On external sources all four codes are accepted.
- R3: A level source is pending while its synchronized input sits at the active level. An edge source latches a pending bit on the selected transition of the synchronized input and holds it until it is cleared.
- R4: Among enabled pending sources, the highest priority wins. Between equal priorities, the lowest source number wins.
- R5: `irq_o` is high only when the winner is enabled and pending, its priority is strictly above the running level (or no level is active), and the stack is not full. Disabled sources never raise it.
- R6: A read of address 0x04 while `irq_o` is high returns the winner's vector, pushes the running level, and makes the winner's priority the new running level.
- R7: That acknowledging read also clears the winner's latched edge bit.
- R8: A read of address 0x04 while `irq_o` is low returns the spurious vector register at address 0x06 and leaves the stack unchanged.
- R9: Any write to address 0x05 (end of interrupt) pops one level. On an empty stack it has no effect.
- R10: Up to 8 levels nest. Eight end-of-interrupt writes unwind a full stack and release `irq_o`.
- R11: Writing address 0x03 clears the latched edge bit of every source whose `wdata` bit is 1.
- R12: The per-source vector registers at 0x80+n and the spurious vector at 0x06 read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Raw interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acknowledge on vector address) |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Register reads are combinational, so the bench samples `rdata` in the low half of the cycle in which `rd_en` is driven. The acknowledge, push or pop then happens at the following rising edge, and `irq_o` reflects it at the next falling edge.

A level input reaches `irq_o` two rising edges after it changes, through the two-stage synchronizer. An edge input needs a third edge to latch its pending bit. The bench therefore waits three or four cycles after driving an input before it checks the request.

Enable and clear writes take effect one edge after the write. The bench checks them at the next falling edge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   typedef enum logic [1:0] {
      TRG_HIGH = 2'd0,
      TRG_RISE = 2'd1,
      TRG_LOW  = 2'd2,
      TRG_FALL = 2'd3
   } trig_e;

   localparam logic [7:0] A_ENA_SET  = 8'h00;
   localparam logic [7:0] A_ENA_CLR  = 8'h01;
   localparam logic [7:0] A_ENA_RD   = 8'h02;
   localparam logic [7:0] A_PEND_CLR = 8'h03;
   localparam logic [7:0] A_VECTOR   = 8'h04;
   localparam logic [7:0] A_EOI      = 8'h05;
   localparam logic [7:0] A_SPUR     = 8'h06;
   localparam logic [7:0] A_MODE     = 8'h40;
   localparam logic [7:0] A_VEC      = 8'h80;

endpackage

// File: rtl/pic_src_cell.sv
module pic_src_cell
   import prio_irq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  src_i,
   input  trig_e trig_i,
   input  logic  clr_i,
   output logic  pend_o
);
   logic [2:0] sh_q;
   logic       pend_q;
   logic       s_now, s_prev, edge_mode, hit;

   assign s_now     = sh_q[1];
   assign s_prev    = sh_q[2];
   assign edge_mode = (trig_i == TRG_RISE) || (trig_i == TRG_FALL);

   always_comb begin
      case (trig_i)
         TRG_RISE: hit = s_now & ~s_prev;
         TRG_FALL: hit = ~s_now & s_prev;
         default:  hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         pend_q <= 1'b0;
      end else begin
         sh_q <= {sh_q[1:0], src_i};
         if (!edge_mode)  pend_q <= 1'b0;
         else if (hit)    pend_q <= 1'b1;
         else if (clr_i)  pend_q <= 1'b0;
      end
   end

   always_comb begin
      case (trig_i)
         TRG_HIGH: pend_o = s_now;
         TRG_LOW:  pend_o = ~s_now;
         default:  pend_o = pend_q;
      endcase
   end

   // R3: a latched edge survives until a clear arrives
   a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode && pend_q && !clr_i && $stable(trig_i) |=> pend_q);

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
   parameter int N  = 32,
   parameter int PW = 3,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]         active_i,
   input  logic [N-1:0][PW-1:0] prio_i,
   output logic                 found_o,
   output logic [IW-1:0]        idx_o,
   output logic [PW-1:0]        best_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      best_o  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (active_i[i] && (!found_o || prio_i[i] >= best_o)) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
            best_o  = prio_i[i];
         end
      end
   end
endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack #(
   parameter int DEPTH = 8,
   parameter int PW    = 3,
   localparam int DW   = $clog2(DEPTH + 1),
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [PW-1:0] push_prio_i,
   input  logic          pop_i,
   output logic [DW-1:0] depth_o,
   output logic [PW-1:0] cur_o,
   output logic          empty_o,
   output logic          full_o
);
   logic [DEPTH-1:0][PW-1:0] mem_q;
   logic [DW-1:0]            depth_q;
   logic [PW-1:0]            cur_q;

   assign depth_o = depth_q;
   assign cur_o   = cur_q;
   assign empty_o = (depth_q == '0);
   assign full_o  = (depth_q == DW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q   <= '0;
         depth_q <= '0;
         cur_q   <= '0;
      end else if (push_i && !full_o) begin
         mem_q[IW'(depth_q)] <= cur_q;
         cur_q               <= push_prio_i;
         depth_q             <= depth_q + DW'(1);
      end else if (pop_i && !empty_o) begin
         cur_q   <= mem_q[IW'(depth_q - DW'(1))];
         depth_q <= depth_q - DW'(1);
      end
   end

   // R10: nesting never exceeds the configured depth
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      depth_q <= DW'(DEPTH));
   // R6: an accepted push deepens the stack by one
   a_r6_push_depth: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && !full_o |=> depth_q == $past(depth_q) + DW'(1));
   // R9: pop on an empty stack keeps it empty
   a_r9_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !push_i && empty_o |=> depth_q == '0);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int          NUM_SRC      = 32,
   parameter int          PRIO_W       = 3,
   parameter int          VEC_W        = 8,
   parameter int          DEPTH        = 8,
   parameter logic [31:0] EXT_SRC_MASK = 32'hF000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [7:0]         addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   output logic               irq_o
);
   localparam int IW = $clog2(NUM_SRC);
   localparam int DW = $clog2(DEPTH + 1);

   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_n
      $error("NUM_SRC must lie in 2..32");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_pw
      $error("PRIO_W must lie in 1..4");
   end
   if (VEC_W < 1 || VEC_W > 32) begin : g_bad_vw
      $error("VEC_W must lie in 1..32");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [NUM_SRC-1:0]             ena_q, pend, active, clr_vec, ack_vec;
   trig_e                          trig_q [NUM_SRC];
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [NUM_SRC-1:0][VEC_W-1:0]  vec_q;
   logic [VEC_W-1:0]               spur_q;

   logic              found, eligible, ack, pop, empty, full;
   logic [IW-1:0]     win_idx;
   logic [PRIO_W-1:0] win_prio, cur_prio;
   logic [DW-1:0]     depth;

   logic wr_set, wr_clr, wr_pclr;
   assign wr_set  = wr_en && addr == A_ENA_SET;
   assign wr_clr  = wr_en && addr == A_ENA_CLR;
   assign wr_pclr = wr_en && addr == A_PEND_CLR;
   assign pop     = wr_en && addr == A_EOI;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena_q  <= '0;
         spur_q <= '0;
      end else begin
         if (wr_set) ena_q <= ena_q | wdata[NUM_SRC-1:0];
         if (wr_clr) ena_q <= ena_q & ~wdata[NUM_SRC-1:0];
         if (wr_en && addr == A_SPUR) spur_q <= wdata[VEC_W-1:0];
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            trig_q[i] <= TRG_HIGH;
            prio_q[i] <= '0;
            vec_q[i]  <= '0;
         end else begin
            if (wr_en && addr == 8'(A_MODE + i)) begin
               prio_q[i] <= wdata[PRIO_W-1:0];
               if (EXT_SRC_MASK[i] || !wdata[5])
                  trig_q[i] <= trig_e'(wdata[5:4]);
            end
            if (wr_en && addr == 8'(A_VEC + i))
               vec_q[i] <= wdata[VEC_W-1:0];
         end
      end

      assign ack_vec[i] = ack && (win_idx == IW'(i));
      assign clr_vec[i] = ack_vec[i] || (wr_pclr && wdata[i]);

      pic_src_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .src_i  (src_i[i]),
         .trig_i (trig_q[i]),
         .clr_i  (clr_vec[i]),
         .pend_o (pend[i])
      );

      if (!EXT_SRC_MASK[i]) begin : g_int
         // R2: internal sources keep a non-inverted trigger
         a_r2_internal_trig: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_q[i][1]);
      end
   end

   assign active = pend & ena_q;

   pic_arbiter #(.N(NUM_SRC), .PW(PRIO_W)) u_arb (
      .active_i (active),
      .prio_i   (prio_q),
      .found_o  (found),
      .idx_o    (win_idx),
      .best_o   (win_prio)
   );

   assign eligible = found && !full && (empty || win_prio > cur_prio);
   assign irq_o    = eligible;
   assign ack      = rd_en && addr == A_VECTOR && eligible;

   pic_level_stack #(.DEPTH(DEPTH), .PW(PRIO_W)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (ack),
      .push_prio_i (win_prio),
      .pop_i       (pop),
      .depth_o     (depth),
      .cur_o       (cur_prio),
      .empty_o     (empty),
      .full_o      (full)
   );

   logic [IW-1:0] sel;
   logic          sel_ok;
   assign sel    = addr[IW-1:0];
   assign sel_ok = addr[5:0] < 6'(NUM_SRC);

   always_comb begin
      rdata = '0;
      if (addr == A_ENA_RD)        rdata[NUM_SRC-1:0] = ena_q;
      else if (addr == A_VECTOR)   rdata[VEC_W-1:0]   = eligible ? vec_q[win_idx] : spur_q;
      else if (addr == A_SPUR)     rdata[VEC_W-1:0]   = spur_q;
      else if (addr[7:6] == 2'b01 && sel_ok) begin
         rdata[PRIO_W-1:0] = prio_q[sel];
         rdata[5:4]        = trig_q[sel];
      end
      else if (addr[7:6] == 2'b10 && sel_ok) rdata[VEC_W-1:0] = vec_q[sel];
   end

   // R1: set and clear writes act on exactly the bits written as one
   a_r1_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> (ena_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0]));
   a_r1_clr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> (ena_q & $past(wdata[NUM_SRC-1:0])) == '0);
   // R5: the request implies an enabled pending source and room on the stack
   a_r5_req_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|(pend & ena_q)) && depth < DW'(DEPTH));
   // R8: a spurious read leaves the nesting depth alone
   a_r8_spur_stable: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == A_VECTOR && !irq_o && !pop |=> $stable(depth));

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_run = 0, n_fail = 0;

   always #5 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic pulse(input int s);
      @(negedge clk); src[s] = 1'b1;
      cyc(2); src[s] = 1'b0;
      cyc(4);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R5 reset irq", {31'b0, irq}, 0);
      rd(8'h02, d); chk("R1 reset mask", d, 0);
      rd(8'h04, d); chk("R8 reset spurious", d, 0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(8'h00, 32'h0000_00F0);
      wr(8'h01, 32'h0000_0030);
      wr(8'h00, 32'h0);
      rd(8'h02, d); chk("R1 set/clr mask", d, 32'h0000_00C0);
      wr(8'h01, 32'hFFFF_FFFF);
      rd(8'h02, d); chk("R1 clear all", d, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(8'h43, 32'h25);
      rd(8'h43, d); chk("R2 internal rejects low-level", d, 32'h05);
      wr(8'h5E, 32'h23);
      rd(8'h5E, d); chk("R2 external accepts falling", d, 32'h23);
      wr(8'h85, 32'hA5);
      rd(8'h85, d); chk("R12 vector readback", d, 32'hA5);
      wr(8'h06, 32'h77);
      rd(8'h06, d); chk("R12 spurious readback", d, 32'h77);
   endtask

   task automatic t_spurious();
      logic [31:0] d;
      rd(8'h04, d); chk("R8 spurious vector", d, 32'h77);
      wr(8'h4B, 32'h00); wr(8'h8B, 32'h0B);
      wr(8'h00, 32'h800);
      src[11] = 1'b1; cyc(3);
      chk("R8 no push after spurious", {31'b0, irq}, 1);
      rd(8'h04, d); chk("R6 prio0 vector", d, 32'h0B);
      wr(8'h05, 0);
      src[11] = 1'b0; wr(8'h01, 32'h800); cyc(3);
   endtask

   task automatic t_level();
      logic [31:0] d;
      wr(8'h42, 32'h04); wr(8'h82, 32'h12);
      @(negedge clk); src[2] = 1'b1; cyc(3);
      chk("R5 disabled source silent", {31'b0, irq}, 0);
      wr(8'h00, 32'h4);
      chk("R3 level pending raises irq", {31'b0, irq}, 1);
      rd(8'h04, d); chk("R6 level vector", d, 32'h12);
      chk("R5 equal level blocked", {31'b0, irq}, 0);
      wr(8'h05, 0);
      chk("R9 eoi re-exposes level", {31'b0, irq}, 1);
      src[2] = 1'b0; cyc(3);
      chk("R3 level drop releases", {31'b0, irq}, 0);
      wr(8'h01, 32'h4);
   endtask

   task automatic t_priority();
      logic [31:0] d;
      wr(8'h46, 32'h03); wr(8'h86, 32'h06);
      wr(8'h49, 32'h03); wr(8'h89, 32'h09);
      wr(8'h41, 32'h02); wr(8'h81, 32'h01);
      wr(8'h4C, 32'h06); wr(8'h8C, 32'h0C);
      wr(8'h00, 32'h1242);
      @(negedge clk); src[6] = 1; src[9] = 1; src[1] = 1; cyc(3);
      rd(8'h04, d); chk("R4 tie lowest index", d, 32'h06);
      chk("R5 lower prio blocked", {31'b0, irq}, 0);
      wr(8'h05, 0);
      src[12] = 1'b1; cyc(3);
      rd(8'h04, d); chk("R4 highest priority", d, 32'h0C);
      wr(8'h05, 0);
      src[6] = 0; src[9] = 0; src[1] = 0; src[12] = 0;
      wr(8'h01, 32'h1242); cyc(3);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      wr(8'h48, 32'h12); wr(8'h88, 32'h38);
      wr(8'h00, 32'h100);
      pulse(8);
      chk("R3 rising latched", {31'b0, irq}, 1);
      wr(8'h03, 32'h100);
      chk("R11 pending clear", {31'b0, irq}, 0);
      pulse(8);
      rd(8'h04, d); chk("R6 edge vector", d, 32'h38);
      wr(8'h05, 0);
      chk("R7 ack clears edge", {31'b0, irq}, 0);
      wr(8'h01, 32'h100);
   endtask

   task automatic t_external();
      logic [31:0] d;
      wr(8'h5D, 32'h31); wr(8'h9D, 32'h29);
      wr(8'h00, 32'h2000_0000);
      @(negedge clk); src[29] = 1'b1; cyc(4);
      chk("R3 falling ignores rise", {31'b0, irq}, 0);
      src[29] = 1'b0; cyc(4);
      chk("R3 falling latched", {31'b0, irq}, 1);
      rd(8'h04, d); chk("R6 falling vector", d, 32'h29);
      wr(8'h05, 0);
      wr(8'h01, 32'h2000_0000);
      wr(8'h5E, 32'h22); wr(8'h00, 32'h4000_0000);
      chk("R3 low-level active", {31'b0, irq}, 1);
      @(negedge clk); src[30] = 1'b1; cyc(3);
      chk("R3 low-level idle when high", {31'b0, irq}, 0);
      src[30] = 1'b0; wr(8'h01, 32'h4000_0000);
   endtask

   task automatic t_nest();
      logic [31:0] d;
      for (int k = 0; k < 9; k++) begin
         wr(8'(8'h50 + k), 32'(8'h10 + k));
         wr(8'(8'h90 + k), 32'(8'h50 + k));
      end
      wr(8'h50 + 8, 32'h10);
      wr(8'h00, 32'h01FF_0000);
      for (int k = 0; k < 8; k++) begin
         pulse(16 + k);
         chk("R5 higher nests", {31'b0, irq}, 1);
         rd(8'h04, d); chk("R6 nested vector", d, 32'(8'h50 + k));
      end
      for (int k = 0; k < 8; k++) begin
         wr(8'h05, 0);
         chk("R10 unwinding quiet", {31'b0, irq}, 0);
      end
      wr(8'h05, 0);
      pulse(24);
      chk("R9 extra eoi harmless", {31'b0, irq}, 1);
      rd(8'h04, d); chk("R10 base level usable", d, 32'h58);
      wr(8'h05, 0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      cyc(3); rst_n = 1'b1; cyc(1);
      t_reset();
      t_enable();
      t_regs();
      t_spurious();
      t_level();
      t_priority();
      t_edge();
      t_external();
      t_nest();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule